// File: doc/BRIEF.md
# Address-Match Debug Trigger Unit

This block provides a small bank of address-match breakpoint triggers for a 64-bit core. Software reaches all triggers through one narrow register window made of three registers: an index register that picks the active trigger, a control register that holds the trigger's class and its enable bits, and a 64-bit compare address. Each trigger can independently watch the instruction fetch address, the load address and the store address. A trigger only fires while the hart runs at the highest privilege level and the trigger's own privilege enable is set.

A match is reported combinationally, in the same cycle as the probe, so the pipeline can raise a breakpoint exception on the faulting instruction itself before it takes effect. A matching store is blocked at the block's store-commit output, so memory is never written. Fetch probes and load/store probes are judged separately, and each has its own hit flag and trigger index. When several triggers match at once, the lowest index wins. The control register's writable bits follow write-any-read-legal rules: unsupported bits are dropped, so the value read back differs from the value written and software can tell that a configuration is not available.

Top module: `addr_trigger_unit`

## Requirements
- R1: After reset every trigger has all enable bits clear and a compare address of zero, the index register reads 0, and no hit is reported for any probe.
- R2: The register window is addressed by `csrSel`: 0 is the index register, 1 is the control register of the selected trigger, 2 is the compare address of the selected trigger, and 3 reads as zero and ignores writes. A write takes effect on the rising clock edge on which `csrWe` is high. Reads are combinational.
- R3: The control register always reads the value 2 in bits 63:60, and writing those bits has no effect.
- R4: In the control register only bit 6 (privilege enable), bit 2 (execute), bit 1 (store) and bit 0 (load) are stored. Every other bit reads as 0, so a write that sets any other bit in 10:0 reads back a different low 11-bit value.
- R5: Writing an index below `NUM_TRIG` to the index register selects that trigger. Writing a larger value leaves the previous index in place, and that index is what reads back.
- R6: The compare address register stores and reads back all 64 bits.
- R7: `fetchHit` is high when `fetchValid` is high, `priv` is 3, and some trigger has its privilege and execute enables set and a compare address equal to `fetchAddr`.
- R8: `memHit` is high for a load only through the load enable and for a store only through the store enable. A trigger enabled only for execute never fires on data accesses, and one enabled only for load never fires on a store.
- R9: No trigger fires when `priv` is not 3 or when its privilege enable is clear.
- R10: `storeCommit` equals `storeValid` except when `memHit` is high, in which case it is low.
- R11: Each trigger keeps its own settings. Writing one trigger's registers leaves the other triggers' settings and matching unchanged.
- R12: When several triggers match the same probe, `fetchHitIdx` or `memHitIdx` gives the lowest matching index. Each index reads 0 when its hit flag is low.
- R13: `fetchCause` and `memCause` read 3 (breakpoint) when their hit flag is high and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csrWe | input | 1 | Register window write strobe |
| csrSel | input | 2 | Register window address (0 index, 1 control, 2 address) |
| csrWdata | input | 64 | Write data |
| csrRdata | output | 64 | Combinational read data |
| priv | input | 2 | Current privilege level (3 = highest) |
| fetchValid | input | 1 | Fetch probe valid |
| fetchAddr | input | 64 | Fetch address |
| loadValid | input | 1 | Load probe valid |
| storeValid | input | 1 | Store probe valid |
| memAddr | input | 64 | Load/store address |
| fetchHit | output | 1 | Breakpoint on fetch |
| fetchHitIdx | output | 1 | Index of the fetch-matching trigger |
| fetchCause | output | 4 | Exception cause for the fetch hit |
| memHit | output | 1 | Breakpoint on load or store |
| memHitIdx | output | 1 | Index of the data-matching trigger |
| memCause | output | 4 | Exception cause for the data hit |
| storeCommit | output | 1 | Store may proceed to memory |

## Verification
Every cycle, the assertions check that a hit only appears with a valid probe at the highest privilege level, that a hit index is always a real trigger, that a blocked store never commits, that the control register's class field always reads 2, and that the index register never reads out of range. Other properties can only be shown by the bench's sweeps. These are the exact matching against each combination of enable bits, privilege and access kind, the read-back of unsupported control bits, the independence of the two triggers, and the lowest-index rule when both match.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int CTL_PRIV_BIT  = 6;
  localparam int CTL_EXEC_BIT  = 2;
  localparam int CTL_STORE_BIT = 1;
  localparam int CTL_LOAD_BIT  = 0;
  localparam logic [3:0] TRIG_CLASS_ADDR = 4'd2;
  localparam logic [3:0] CAUSE_BREAK     = 4'd3;
  localparam logic [1:0] PRIV_TOP        = 2'd3;

  typedef enum logic [1:0] {
    WIN_INDEX = 2'd0,
    WIN_CTL   = 2'd1,
    WIN_ADDR  = 2'd2,
    WIN_NONE  = 2'd3
  } winSel_t;

  typedef struct packed {
    logic ctlWe;
    logic adrWe;
  } trigStrobe_t;

  typedef struct packed {
    logic privEn;
    logic execEn;
    logic storeEn;
    logic loadEn;
  } trigCfg_t;
endpackage

// File: rtl/trig_ctrl.sv
module trig_ctrl
  import trig_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int NUM_TRIG = 2,
  parameter int SEL_W    = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csrWe,
  input  logic [1:0]       csrSel,
  input  logic [XLEN-1:0]  csrWdata,
  input  logic [XLEN-1:0]  ctlRd,
  input  logic [XLEN-1:0]  adrRd,
  output trigStrobe_t      strobe,
  output logic [SEL_W-1:0] selIdx,
  output logic [XLEN-1:0]  csrRdata
);
  winSel_t win;
  logic    idxLegal;

  assign win      = winSel_t'(csrSel);
  assign idxLegal = (csrWdata < XLEN'(NUM_TRIG));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selIdx <= '0;
    end else if (csrWe && win == WIN_INDEX && idxLegal) begin
      selIdx <= csrWdata[SEL_W-1:0];
    end
  end

  always_comb begin
    strobe.ctlWe = csrWe && (win == WIN_CTL);
    strobe.adrWe = csrWe && (win == WIN_ADDR);
  end

  always_comb begin
    unique case (win)
      WIN_INDEX: csrRdata = XLEN'(selIdx);
      WIN_CTL:   csrRdata = ctlRd;
      WIN_ADDR:  csrRdata = adrRd;
      default:   csrRdata = '0;
    endcase
  end
endmodule

// File: rtl/trig_datapath.sv
module trig_datapath
  import trig_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int NUM_TRIG = 2,
  parameter int SEL_W    = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  trigStrobe_t      strobe,
  input  logic [SEL_W-1:0] selIdx,
  input  logic [XLEN-1:0]  wdata,
  input  logic [1:0]       priv,
  input  logic             fetchValid,
  input  logic [XLEN-1:0]  fetchAddr,
  input  logic             loadValid,
  input  logic             storeValid,
  input  logic [XLEN-1:0]  memAddr,
  output logic [XLEN-1:0]  ctlRd,
  output logic [XLEN-1:0]  adrRd,
  output logic             fetchHit,
  output logic [SEL_W-1:0] fetchHitIdx,
  output logic             memHit,
  output logic [SEL_W-1:0] memHitIdx
);
  trigCfg_t        cfg   [NUM_TRIG];
  logic [XLEN-1:0] cmpAdr[NUM_TRIG];
  logic [NUM_TRIG-1:0] fetchMatch;
  logic [NUM_TRIG-1:0] memMatch;
  logic            topPriv;

  assign topPriv = (priv == PRIV_TOP);

  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
    logic pick;
    assign pick = (selIdx == SEL_W'(t));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfg[t]    <= '0;
        cmpAdr[t] <= '0;
      end else begin
        if (strobe.ctlWe && pick) begin
          cfg[t].privEn  <= wdata[CTL_PRIV_BIT];
          cfg[t].execEn  <= wdata[CTL_EXEC_BIT];
          cfg[t].storeEn <= wdata[CTL_STORE_BIT];
          cfg[t].loadEn  <= wdata[CTL_LOAD_BIT];
        end
        if (strobe.adrWe && pick) begin
          cmpAdr[t] <= wdata;
        end
      end
    end

    assign fetchMatch[t] = fetchValid && topPriv && cfg[t].privEn &&
                           cfg[t].execEn && (fetchAddr == cmpAdr[t]);
    assign memMatch[t]   = topPriv && cfg[t].privEn && (memAddr == cmpAdr[t]) &&
                           ((loadValid && cfg[t].loadEn) ||
                            (storeValid && cfg[t].storeEn));
  end

  always_comb begin
    trigCfg_t c;
    c     = cfg[selIdx];
    ctlRd = '0;
    ctlRd[XLEN-1 -: 4]   = TRIG_CLASS_ADDR;
    ctlRd[CTL_PRIV_BIT]  = c.privEn;
    ctlRd[CTL_EXEC_BIT]  = c.execEn;
    ctlRd[CTL_STORE_BIT] = c.storeEn;
    ctlRd[CTL_LOAD_BIT]  = c.loadEn;
    adrRd = cmpAdr[selIdx];
  end

  always_comb begin
    fetchHitIdx = '0;
    memHitIdx   = '0;
    for (int t = NUM_TRIG - 1; t >= 0; t--) begin
      if (fetchMatch[t]) fetchHitIdx = SEL_W'(t);
      if (memMatch[t])   memHitIdx   = SEL_W'(t);
    end
    fetchHit = |fetchMatch;
    memHit   = |memMatch;
  end
endmodule

// File: rtl/addr_trigger_unit.sv
module addr_trigger_unit
  import trig_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int NUM_TRIG = 2,
  localparam int SEL_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csrWe,
  input  logic [1:0]       csrSel,
  input  logic [XLEN-1:0]  csrWdata,
  output logic [XLEN-1:0]  csrRdata,
  input  logic [1:0]       priv,
  input  logic             fetchValid,
  input  logic [XLEN-1:0]  fetchAddr,
  input  logic             loadValid,
  input  logic             storeValid,
  input  logic [XLEN-1:0]  memAddr,
  output logic             fetchHit,
  output logic [SEL_W-1:0] fetchHitIdx,
  output logic [3:0]       fetchCause,
  output logic             memHit,
  output logic [SEL_W-1:0] memHitIdx,
  output logic [3:0]       memCause,
  output logic             storeCommit
);
  trigStrobe_t      strobe;
  logic [SEL_W-1:0] selIdx;
  logic [XLEN-1:0]  ctlRd;
  logic [XLEN-1:0]  adrRd;

  trig_ctrl #(.XLEN(XLEN), .NUM_TRIG(NUM_TRIG), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .csrWe(csrWe), .csrSel(csrSel),
    .csrWdata(csrWdata), .ctlRd(ctlRd), .adrRd(adrRd),
    .strobe(strobe), .selIdx(selIdx), .csrRdata(csrRdata)
  );

  trig_datapath #(.XLEN(XLEN), .NUM_TRIG(NUM_TRIG), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .selIdx(selIdx),
    .wdata(csrWdata), .priv(priv), .fetchValid(fetchValid),
    .fetchAddr(fetchAddr), .loadValid(loadValid), .storeValid(storeValid),
    .memAddr(memAddr), .ctlRd(ctlRd), .adrRd(adrRd),
    .fetchHit(fetchHit), .fetchHitIdx(fetchHitIdx),
    .memHit(memHit), .memHitIdx(memHitIdx)
  );

  assign fetchCause  = fetchHit ? CAUSE_BREAK : 4'd0;
  assign memCause    = memHit ? CAUSE_BREAK : 4'd0;
  assign storeCommit = storeValid && !memHit;
endmodule

// File: rtl/trig_checker.sv
module trig_checker #(
  parameter int XLEN     = 64,
  parameter int NUM_TRIG = 2,
  parameter int SEL_W    = 1
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       csrSel,
  input logic [XLEN-1:0]  csrRdata,
  input logic [1:0]       priv,
  input logic             fetchValid,
  input logic             loadValid,
  input logic             storeValid,
  input logic             fetchHit,
  input logic [SEL_W-1:0] fetchHitIdx,
  input logic             memHit,
  input logic [SEL_W-1:0] memHitIdx,
  input logic             storeCommit
);
  // R7 R9: a fetch hit needs a valid fetch at the top privilege level
  a_r7_fetch_qualified: assert property (@(posedge clk) disable iff (!rstN)
    fetchHit |-> (fetchValid && priv == 2'd3));

  // R8 R9: a data hit needs a data access at the top privilege level
  a_r8_mem_qualified: assert property (@(posedge clk) disable iff (!rstN)
    memHit |-> ((loadValid || storeValid) && priv == 2'd3));

  // R10: a blocked store never commits
  a_r10_store_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (storeValid && memHit) |-> !storeCommit);

  // R10: commit only for a real store
  a_r10_commit_needs_store: assert property (@(posedge clk) disable iff (!rstN)
    storeCommit |-> storeValid);

  // R3: class field of the control register
  a_r3_class_field: assert property (@(posedge clk) disable iff (!rstN)
    (csrSel == 2'd1) |-> (csrRdata[XLEN-1 -: 4] == 4'd2));

  // R5: the index register never reads out of range
  a_r5_index_range: assert property (@(posedge clk) disable iff (!rstN)
    (csrSel == 2'd0) |-> (csrRdata < XLEN'(NUM_TRIG)));

  // R12: hit indices name real triggers
  a_r12_idx_range: assert property (@(posedge clk) disable iff (!rstN)
    (32'(fetchHitIdx) < NUM_TRIG) && (32'(memHitIdx) < NUM_TRIG));
endmodule

bind addr_trigger_unit trig_checker #(
  .XLEN(XLEN), .NUM_TRIG(NUM_TRIG), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rstN(rstN), .csrSel(csrSel), .csrRdata(csrRdata),
  .priv(priv), .fetchValid(fetchValid), .loadValid(loadValid),
  .storeValid(storeValid), .fetchHit(fetchHit), .fetchHitIdx(fetchHitIdx),
  .memHit(memHit), .memHitIdx(memHitIdx), .storeCommit(storeCommit)
);

// File: tb/sim_addr_trigger_unit.sv
module sim_addr_trigger_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csrWe = 1'b0;
  logic [1:0]  csrSel = 2'd0;
  logic [63:0] csrWdata = '0;
  logic [63:0] csrRdata;
  logic [1:0]  priv = 2'd0;
  logic        fetchValid = 1'b0;
  logic [63:0] fetchAddr = '0;
  logic        loadValid = 1'b0;
  logic        storeValid = 1'b0;
  logic [63:0] memAddr = '0;
  logic        fetchHit, memHit, storeCommit;
  logic [0:0]  fetchHitIdx, memHitIdx;
  logic [3:0]  fetchCause, memCause;

  int vecCount = 0;
  int errCount = 0;
  bit done = 1'b0;

  localparam logic [63:0] ADR_A = 64'h8000_0000_0000_1000;
  localparam logic [63:0] ADR_B = 64'h8000_0000_0000_2040;

  always #2.5 clk = ~clk;

  addr_trigger_unit #(.XLEN(64), .NUM_TRIG(2)) u0 (
    .clk(clk), .rstN(rstN), .csrWe(csrWe), .csrSel(csrSel),
    .csrWdata(csrWdata), .csrRdata(csrRdata), .priv(priv),
    .fetchValid(fetchValid), .fetchAddr(fetchAddr), .loadValid(loadValid),
    .storeValid(storeValid), .memAddr(memAddr), .fetchHit(fetchHit),
    .fetchHitIdx(fetchHitIdx), .fetchCause(fetchCause), .memHit(memHit),
    .memHitIdx(memHitIdx), .memCause(memCause), .storeCommit(storeCommit)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vecCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic csrWr(input logic [1:0] sel, input logic [63:0] d);
    @(negedge clk);
    csrWe = 1'b1; csrSel = sel; csrWdata = d;
    @(negedge clk);
    csrWe = 1'b0;
  endtask

  task automatic csrRd(input logic [1:0] sel, output logic [63:0] d);
    @(negedge clk);
    csrSel = sel;
    #1 d = csrRdata;
  endtask

  task automatic idle();
    fetchValid = 1'b0; loadValid = 1'b0; storeValid = 1'b0;
  endtask

  // kind 0 fetch, 1 load, 2 store
  task automatic probe(input int kind, input logic [63:0] a, input logic [1:0] p);
    idle();
    priv = p;
    fetchAddr = a; memAddr = a;
    case (kind)
      0: fetchValid = 1'b1;
      1: loadValid = 1'b1;
      default: storeValid = 1'b1;
    endcase
    #1;
  endtask

  initial begin
    logic [63:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    csrRd(2'd0, rd); chk("R1 index", rd, 64'd0);
    csrRd(2'd1, rd); chk("R1 ctl", rd, 64'h2000_0000_0000_0000);
    csrRd(2'd2, rd); chk("R1 addr", rd, 64'd0);
    for (int k = 0; k < 3; k++) begin
      probe(k, 64'd0, 2'd3);
      chk("R1 no fetch hit", fetchHit, 0);
      chk("R1 no mem hit", memHit, 0);
    end
    idle();

    // R2: window slot 3 reads zero and ignores writes
    csrWr(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    csrRd(2'd3, rd); chk("R2 slot3", rd, 64'd0);
    csrRd(2'd1, rd); chk("R2 slot3 no side effect", rd, 64'h2000_0000_0000_0000);

    // R5: index sweep
    for (int v = 0; v < 8; v++) begin
      csrWr(2'd0, 64'(v));
      csrRd(2'd0, rd);
      chk("R5 index", rd, (v < 2) ? 64'(v) : 64'd1);
    end
    csrWr(2'd0, 64'd0);
    csrRd(2'd0, rd); chk("R5 index back to 0", rd, 64'd0);

    // R3 R4: low 11-bit sweep with top nibble garbage
    for (int v = 0; v < 2048; v++) begin
      csrWr(2'd1, {4'hF, 49'd0, 11'(v)});
      csrRd(2'd1, rd);
      chk("R3 R4 ctl readback", rd,
          {4'h2, 49'd0, 11'(v & 32'h47)});
    end

    // R6: address readback
    csrWr(2'd2, 64'hDEAD_BEEF_0123_4567);
    csrRd(2'd2, rd); chk("R6 addr", rd, 64'hDEAD_BEEF_0123_4567);
    csrWr(2'd2, ADR_A);
    csrRd(2'd2, rd); chk("R6 addr A", rd, ADR_A);

    // R7 R8 R9 R10 R13: sweep of trigger 0 configs
    for (int c = 0; c < 16; c++) begin
      logic [63:0] w;
      w = (64'(c >> 3) << 6) | 64'(c & 7);
      idle();
      csrWr(2'd1, w);
      for (int p = 0; p < 4; p++) begin
        for (int k = 0; k < 3; k++) begin
          for (int m = 0; m < 2; m++) begin
            bit en, expH;
            en = (k == 0) ? c[2] : (k == 1) ? c[0] : c[1];
            expH = c[3] && (p == 3) && en && (m == 1);
            probe(k, (m == 1) ? ADR_A : (ADR_A ^ 64'h4), 2'(p));
            if (k == 0) begin
              chk("R7 R9 fetchHit", fetchHit, expH);
              chk("R8 memHit quiet on fetch", memHit, 0);
              chk("R13 fetchCause", fetchCause, expH ? 4'd3 : 4'd0);
            end else begin
              chk("R8 R9 memHit", memHit, expH);
              chk("R7 fetchHit quiet on data", fetchHit, 0);
              chk("R13 memCause", memCause, expH ? 4'd3 : 4'd0);
              chk("R10 storeCommit", storeCommit, (k == 2) && !expH);
            end
          end
        end
      end
    end
    idle();

    // R11: trigger 0 = priv+load at A; configure trigger 1 = priv+exec at B
    csrWr(2'd1, 64'h41);
    csrWr(2'd0, 64'd1);
    csrWr(2'd1, 64'h44);
    csrWr(2'd2, ADR_B);
    csrWr(2'd0, 64'd0);
    csrRd(2'd1, rd); chk("R11 trig0 ctl kept", rd, 64'h2000_0000_0000_0041);
    csrRd(2'd2, rd); chk("R11 trig0 addr kept", rd, ADR_A);
    probe(1, ADR_A, 2'd3);
    chk("R11 trig0 load hit", memHit, 1); chk("R12 idx0", memHitIdx, 0);
    probe(0, ADR_B, 2'd3);
    chk("R11 trig1 fetch hit", fetchHit, 1); chk("R12 idx1", fetchHitIdx, 1);
    probe(0, ADR_A, 2'd3);
    chk("R11 trig0 no exec", fetchHit, 0); chk("R12 idx zero when idle", fetchHitIdx, 0);
    probe(2, ADR_A, 2'd3);
    chk("R8 load-only ignores store", memHit, 0);
    chk("R10 store commits", storeCommit, 1);
    idle();

    // R12: both triggers on A with all enables -> lowest index wins
    csrWr(2'd1, 64'h47);
    csrWr(2'd0, 64'd1);
    csrWr(2'd1, 64'h47);
    csrWr(2'd2, ADR_A);
    for (int k = 0; k < 3; k++) begin
      probe(k, ADR_A, 2'd3);
      if (k == 0) begin
        chk("R12 fetch priority hit", fetchHit, 1);
        chk("R12 fetch priority idx", fetchHitIdx, 0);
      end else begin
        chk("R12 mem priority hit", memHit, 1);
        chk("R12 mem priority idx", memHitIdx, 0);
      end
    end
    idle();
    // disable trigger 0 -> trigger 1 reported
    csrWr(2'd0, 64'd0);
    csrWr(2'd1, 64'h0);
    probe(1, ADR_A, 2'd3);
    chk("R12 fallback idx1", memHitIdx, 1);
    chk("R11 trig1 still hits", memHit, 1);
    idle();

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vecCount++;
      errCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  end
endmodule